// File: doc/BRIEF.md
# Iterative Integer Divider with Exact Condition Flags

This block divides integers over many clock cycles for a processor execute stage. It has three forms. The word form divides a 32-bit dividend by a 16-bit divisor and returns one packed 32-bit result. The long form divides a 32-bit dividend by a 32-bit divisor. The quad form divides a 64-bit dividend by a 32-bit divisor. Each form can be signed or unsigned.

An operation starts with a one-cycle `start` strobe that carries the mode, the operands and the two destination register indices. Some cycles later a single `done` pulse returns four things: the quotient and remainder values, a write enable for each of the two destination registers, and the four condition flags N, Z, V and C with their own update enable.

A zero divisor is reported on `div0` and changes nothing. On overflow the destinations are left as they were, V is set and N keeps the value it had before. The register file and the exception sequence that follows a `div0` lie outside this block.

Top module: `div_unit`

## Requirements
- R1: A zero divisor ends the operation one cycle after `start` with `done` and `div0` both high. No write enable and no flag update are given. In the word form only `divisor[15:0]` is tested for zero.
- R2: In the word form, `res_q[15:0]` holds the quotient and `res_q[31:16]` holds the remainder. Only `wr_q` is raised.
- R3: Word-form overflow occurs in two cases. Unsigned: the quotient exceeds 0xFFFF. Signed: the quotient falls outside -32768..32767.
- R4: On overflow the block sets V=1, C=0 and Z=0, returns N equal to `n_in` as sampled at `start`, and raises neither write enable.
- R5: Without overflow the block sets C=0 and V=0. N and Z come from the quotient: its low 16 bits in the word form, its 32 bits in the long and quad forms.
- R6: The mode field selects the form: 0 is word, 1 is long, 2 and 3 are quad. The quad dividend is {`dividend_hi`, `dividend_lo`}. The long and quad forms overflow when the quotient does not fit in 32 bits, signed or unsigned as selected.
- R7: In the quad form and the ordinary long form, `wr_q` is raised on success. `wr_r` is raised only when `q_sel` differs from `r_sel`.
- R8: With `reduced` set, the long form (mode 1) writes only the quotient when `q_sel` equals `r_sel`, and otherwise only the remainder. `reduced` has no effect in the other modes.
- R9: Signed division truncates toward zero. The remainder takes the sign of the dividend.
- R10: Every output is low after reset. For a non-zero divisor, `done` rises 33 cycles after the edge that samples `start` in the word and long forms, and 65 cycles after it in the quad form.
- R11: A `start` that arrives while an operation is in progress is ignored and produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation with the operands presented this cycle |
| mode | input | 2 | Form: 0 word, 1 long, 2 or 3 quad |
| sgn | input | 1 | Signed operation when high |
| reduced | input | 1 | Reduced write rule for the long form |
| q_sel | input | 3 | Quotient destination register index |
| r_sel | input | 3 | Remainder destination register index |
| dividend_lo | input | 32 | Dividend, or its lower half in the quad form |
| dividend_hi | input | 32 | Upper dividend half, used only in the quad form |
| divisor | input | 32 | Divisor; only bits 15:0 are used in the word form |
| n_in | input | 1 | Current N flag, returned unchanged on overflow |
| done | output | 1 | One-cycle completion pulse |
| div0 | output | 1 | Divide-by-zero indication, valid with done |
| res_q | output | 32 | Quotient, or the packed remainder and quotient in the word form |
| res_r | output | 32 | Remainder |
| wr_q | output | 1 | Write enable for the quotient register |
| wr_r | output | 1 | Write enable for the remainder register |
| flags_we | output | 1 | Condition flag update enable |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag, always cleared when flags update |

## Verification
The bench targets the boundaries of overflow in each form:
- A signed word quotient of -32768 must succeed and 32768 must overflow. A design with an off-by-one limit either refuses a valid result or writes a wrapped one.
- The most negative long value divided by -1 must overflow rather than return a negated minimum.
- On overflow, a design that computes N from the quotient instead of keeping `n_in` would show a wrong N.

The bench also covers the write rules and the sign handling:
- With equal register indices, a wrong write rule shows up as a stray `wr_r`. The reduced long form must write exactly one of the two registers.
- Divisors that are zero only in their low half catch a word-form zero test that looks at the wrong bits.
- Mixed-sign operands catch remainder sign errors.
- A `start` issued while busy with a zero divisor catches a design that accepts new work early.

// File: rtl/div_pkg.sv
// Shared definitions for the iterative divider.
// Assumes a 2-bit mode field in which codes 2 and 3 both select the quad form.
package div_pkg;
    localparam logic [1:0] MODE_WORD = 2'd0;
    localparam logic [1:0] MODE_LONG = 2'd1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } div_state_e;
endpackage

// File: rtl/div_prep.sv
// Operand preparation: forms sign-extended operands, takes magnitudes and
// left-aligns short dividends so the engine always shifts from bit DW-1.
// Assumes QW is even; the word form uses the low QW/2 divisor bits.
module div_prep #(
    parameter int QW = 32
) (
    input  logic [1:0]      mode,
    input  logic            sgn,
    input  logic [QW-1:0]   lo,
    input  logic [QW-1:0]   hi,
    input  logic [QW-1:0]   dv,
    output logic [2*QW-1:0] dd_mag,
    output logic [QW-1:0]   dv_mag,
    output logic            neg_dd,
    output logic            neg_q,
    output logic            zero_dv,
    output logic            is_quad
);
    localparam int HW = QW / 2;
    localparam int DW = 2 * QW;

    logic [DW-1:0] dd_full;
    logic [DW-1:0] dd_abs;
    logic [QW-1:0] dv_full;
    logic          neg_dv;

    // Build signed/unsigned operands and their magnitudes.
    always_comb begin
        is_quad = mode[1];
        dd_full = is_quad ? {hi, lo} : {{QW{sgn & lo[QW-1]}}, lo};
        dv_full = (mode == div_pkg::MODE_WORD) ? {{HW{sgn & dv[HW-1]}}, dv[HW-1:0]} : dv;
        neg_dd  = sgn & dd_full[DW-1];
        neg_dv  = sgn & dv_full[QW-1];
        dd_abs  = neg_dd ? (~dd_full + 1'b1) : dd_full;
        dv_mag  = neg_dv ? (~dv_full + 1'b1) : dv_full;
        dd_mag  = is_quad ? dd_abs : {dd_abs[QW-1:0], {QW{1'b0}}};
        zero_dv = (dv_full == '0);
        neg_q   = neg_dd ^ neg_dv;
    end
endmodule

// File: rtl/div_engine.sv
// Restoring divider engine: one quotient bit per step on magnitudes.
// Assumes the dividend is left-aligned in dd_mag and the divisor is non-zero.
module div_engine #(
    parameter int QW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            step,
    input  logic [2*QW-1:0] dd_mag,
    input  logic [QW-1:0]   dv_mag,
    output logic [2*QW-1:0] quo,
    output logic [QW-1:0]   rem
);
    localparam int DW = 2 * QW;

    logic [QW-1:0] dvs;
    logic [QW:0]   shifted;
    logic [QW:0]   diff;
    logic          ge;

    // Trial subtraction of the divisor from the shifted partial remainder.
    always_comb begin
        shifted = {rem, quo[DW-1]};
        diff    = shifted - {1'b0, dvs};
        ge      = ~diff[QW];
    end

    // Load operands, then shift one dividend bit in per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo <= '0;
            rem <= '0;
            dvs <= '0;
        end else if (load) begin
            quo <= dd_mag;
            rem <= '0;
            dvs <= dv_mag;
        end else if (step) begin
            rem <= ge ? diff[QW-1:0] : shifted[QW-1:0];
            quo <= {quo[DW-2:0], ge};
        end
    end
endmodule

// File: rtl/div_finish.sv
// Result stage: sign fix-up, overflow detection, flags and write enables.
// Assumes quo/rem hold final magnitudes when the outputs are used.
module div_finish #(
    parameter int QW = 32
) (
    input  logic [1:0]      mode,
    input  logic            sgn,
    input  logic            reduced,
    input  logic            same,
    input  logic            n_keep,
    input  logic            neg_q,
    input  logic            neg_dd,
    input  logic [2*QW-1:0] quo,
    input  logic [QW-1:0]   rem,
    output logic [QW-1:0]   q_out,
    output logic [QW-1:0]   r_out,
    output logic            wq,
    output logic            wr,
    output logic            fn,
    output logic            fz,
    output logic            fv
);
    localparam int HW = QW / 2;
    localparam int DW = 2 * QW;

    logic [DW-1:0] one;
    logic [DW-1:0] lim;
    logic [QW-1:0] q_s;
    logic [QW-1:0] r_s;
    logic          is_word;
    logic          ovf;
    int            width;

    // Signed results and the quotient magnitude limit for the form.
    always_comb begin
        one     = DW'(1);
        is_word = (mode == div_pkg::MODE_WORD);
        width   = is_word ? HW : QW;
        if (!sgn)       lim = (one << width) - one;
        else if (neg_q) lim = one << (width - 1);
        else            lim = (one << (width - 1)) - one;
        ovf = (quo > lim);
        q_s = neg_q ? (~quo[QW-1:0] + 1'b1) : quo[QW-1:0];
        r_s = neg_dd ? (~rem + 1'b1) : rem;
    end

    // Pick outputs, flags and write enables.
    always_comb begin
        r_out = r_s;
        fv    = 1'b0;
        if (is_word) begin
            q_out = {r_s[HW-1:0], q_s[HW-1:0]};
            fn    = q_s[HW-1];
            fz    = (q_s[HW-1:0] == '0);
            wq    = 1'b1;
            wr    = 1'b0;
        end else begin
            q_out = q_s;
            fn    = q_s[QW-1];
            fz    = (q_s == '0);
            if (reduced && mode == div_pkg::MODE_LONG) begin
                wq = same;
                wr = ~same;
            end else begin
                wq = 1'b1;
                wr = ~same;
            end
        end
        if (ovf) begin
            wq = 1'b0;
            wr = 1'b0;
            fn = n_keep;
            fz = 1'b0;
            fv = 1'b1;
        end
    end
endmodule

// File: rtl/div_unit.sv
// Top of the iterative divider: control sequencing and registered outputs.
// Assumes start is honoured only while idle; results appear on a done pulse.
module div_unit #(
    parameter int QW  = 32,
    parameter int RIW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [1:0]     mode,
    input  logic           sgn,
    input  logic           reduced,
    input  logic [RIW-1:0] q_sel,
    input  logic [RIW-1:0] r_sel,
    input  logic [QW-1:0]  dividend_lo,
    input  logic [QW-1:0]  dividend_hi,
    input  logic [QW-1:0]  divisor,
    input  logic           n_in,
    output logic           done,
    output logic           div0,
    output logic [QW-1:0]  res_q,
    output logic [QW-1:0]  res_r,
    output logic           wr_q,
    output logic           wr_r,
    output logic           flags_we,
    output logic           flag_n,
    output logic           flag_z,
    output logic           flag_v,
    output logic           flag_c
);
    import div_pkg::*;

    localparam int DW = 2 * QW;
    localparam int CW = $clog2(DW);

    div_state_e    state;
    logic [CW-1:0] cnt;
    logic [1:0]    mode_r;
    logic          sgn_r, red_r, same_r, nkeep_r, negq_r, negdd_r;

    logic [DW-1:0] dd_mag, quo;
    logic [QW-1:0] dv_mag, rem, f_q, f_r;
    logic          p_negdd, p_negq, p_zero, p_quad;
    logic          f_wq, f_wr, f_n, f_z, f_v;
    logic          accept;

    assign accept = (state == ST_IDLE) && start && !p_zero;

    div_prep #(.QW(QW)) u_prep (
        .mode(mode), .sgn(sgn), .lo(dividend_lo), .hi(dividend_hi), .dv(divisor),
        .dd_mag(dd_mag), .dv_mag(dv_mag), .neg_dd(p_negdd), .neg_q(p_negq),
        .zero_dv(p_zero), .is_quad(p_quad)
    );

    div_engine #(.QW(QW)) u_engine (
        .clk(clk), .rst_n(rst_n), .load(accept), .step(state == ST_RUN),
        .dd_mag(dd_mag), .dv_mag(dv_mag), .quo(quo), .rem(rem)
    );

    div_finish #(.QW(QW)) u_finish (
        .mode(mode_r), .sgn(sgn_r), .reduced(red_r), .same(same_r), .n_keep(nkeep_r),
        .neg_q(negq_r), .neg_dd(negdd_r), .quo(quo), .rem(rem),
        .q_out(f_q), .r_out(f_r), .wq(f_wq), .wr(f_wr), .fn(f_n), .fz(f_z), .fv(f_v)
    );

    // Sequence idle/run/finish and register the reported results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            mode_r   <= '0;
            sgn_r    <= 1'b0;
            red_r    <= 1'b0;
            same_r   <= 1'b0;
            nkeep_r  <= 1'b0;
            negq_r   <= 1'b0;
            negdd_r  <= 1'b0;
            done     <= 1'b0;
            div0     <= 1'b0;
            res_q    <= '0;
            res_r    <= '0;
            wr_q     <= 1'b0;
            wr_r     <= 1'b0;
            flags_we <= 1'b0;
            flag_n   <= 1'b0;
            flag_z   <= 1'b0;
            flag_v   <= 1'b0;
            flag_c   <= 1'b0;
        end else begin
            done     <= 1'b0;
            div0     <= 1'b0;
            wr_q     <= 1'b0;
            wr_r     <= 1'b0;
            flags_we <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start && p_zero) begin
                        done <= 1'b1;
                        div0 <= 1'b1;
                    end else if (start) begin
                        state   <= ST_RUN;
                        cnt     <= p_quad ? CW'(DW - 1) : CW'(QW - 1);
                        mode_r  <= mode;
                        sgn_r   <= sgn;
                        red_r   <= reduced;
                        same_r  <= (q_sel == r_sel);
                        nkeep_r <= n_in;
                        negq_r  <= p_negq;
                        negdd_r <= p_negdd;
                    end
                end
                ST_RUN: begin
                    if (cnt == '0) state <= ST_FIN;
                    else           cnt   <= cnt - 1'b1;
                end
                default: begin
                    state    <= ST_IDLE;
                    done     <= 1'b1;
                    flags_we <= 1'b1;
                    wr_q     <= f_wq;
                    wr_r     <= f_wr;
                    res_q    <= f_q;
                    res_r    <= f_r;
                    flag_n   <= f_n;
                    flag_z   <= f_z;
                    flag_v   <= f_v;
                    flag_c   <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/div_checker.sv
// Protocol checker for div_unit, attached through bind.
// Assumes results are only meaningful in the cycle done is high.
module div_checker (
    input logic clk,
    input logic rst_n,
    input logic done,
    input logic div0,
    input logic wr_q,
    input logic wr_r,
    input logic flags_we,
    input logic flag_z,
    input logic flag_v,
    input logic flag_c
);
    // R1
    div0_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div0 |-> (done && !wr_q && !wr_r && !flags_we));

    // R4
    overflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_we && flag_v) |-> (!flag_c && !flag_z && !wr_q && !wr_r));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_we && !flag_v) |-> (!flag_c && (wr_q || wr_r)));

    // R10
    quiet_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (!wr_q && !wr_r && !flags_we && !div0));

    // R7
    flag_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we |-> (done && !div0));
endmodule

bind div_unit div_checker u_div_checker (
    .clk(clk), .rst_n(rst_n), .done(done), .div0(div0), .wr_q(wr_q), .wr_r(wr_r),
    .flags_we(flags_we), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
);

// File: tb/div_unit_test.sv
`timescale 1ns/1ps
// Scoreboard bench for div_unit: the driver queues expected results, the
// monitor compares each done pulse against the head of the queue.
module div_unit_test;
    typedef struct {
        logic        div0, wq, wr, fwe, n, z, v;
        logic [31:0] q, r;
        int          lat;
        int          t0;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  mode = '0;
    logic        sgn = 1'b0, reduced = 1'b0, n_in = 1'b0;
    logic [2:0]  q_sel = '0, r_sel = '0;
    logic [31:0] lo = '0, hi = '0, dv = '0;
    logic        done, div0, wr_q, wr_r, flags_we, flag_n, flag_z, flag_v, flag_c;
    logic [31:0] res_q, res_r;

    int    total = 0;
    int    bad = 0;
    int    cyc = 0;
    int    stray = 0;
    exp_t  exp_q[$];
    string tag_q[$];

    div_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .sgn(sgn), .reduced(reduced),
        .q_sel(q_sel), .r_sel(r_sel), .dividend_lo(lo), .dividend_hi(hi), .divisor(dv),
        .n_in(n_in), .done(done), .div0(div0), .res_q(res_q), .res_r(res_r),
        .wr_q(wr_q), .wr_r(wr_r), .flags_we(flags_we), .flag_n(flag_n),
        .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // Expected result computed from the requirements.
    function automatic exp_t model(input logic [1:0] m, input logic s, input logic red,
                                   input logic [2:0] qi, input logic [2:0] ri,
                                   input logic [31:0] a_lo, input logic [31:0] a_hi,
                                   input logic [31:0] d, input logic nk);
        exp_t        e;
        logic [63:0] a, b, qm, rm, qv, lim;
        logic [31:0] rv;
        logic        na, nb, nq, word, ov;
        e = '{default: '0};
        word = (m == 2'd0);
        a  = (m >= 2'd2) ? {a_hi, a_lo} : {{32{s & a_lo[31]}}, a_lo};
        b  = word ? {{48{s & d[15]}}, d[15:0]} : {{32{s & d[31]}}, d};
        na = s & a[63];
        nb = s & b[63];
        if (b == 64'd0) begin
            e.div0 = 1'b1;
            e.lat  = 1;
            return e;
        end
        if (na) a = -a;
        if (nb) b = -b;
        qm = a / b;
        rm = a % b;
        nq = na ^ nb;
        qv = nq ? -qm : qm;
        rv = na ? -rm[31:0] : rm[31:0];
        if (word) lim = s ? (nq ? 64'h8000 : 64'h7FFF) : 64'hFFFF;
        else      lim = s ? (nq ? 64'h8000_0000 : 64'h7FFF_FFFF) : 64'hFFFF_FFFF;
        ov    = qm > lim;
        e.fwe = 1'b1;
        e.lat = (m >= 2'd2) ? 66 : 34;
        if (ov) begin
            e.v = 1'b1;
            e.n = nk;
        end else if (word) begin
            e.q  = {rv[15:0], qv[15:0]};
            e.wq = 1'b1;
            e.n  = qv[15];
            e.z  = (qv[15:0] == 16'd0);
        end else begin
            e.q = qv[31:0];
            e.r = rv;
            e.n = qv[31];
            e.z = (qv[31:0] == 32'd0);
            if (red && m == 2'd1) begin
                e.wq = (qi == ri);
                e.wr = (qi != ri);
            end else begin
                e.wq = 1'b1;
                e.wr = (qi != ri);
            end
        end
        return e;
    endfunction

    task automatic drive(input logic [1:0] m, input logic s, input logic red,
                         input logic [2:0] qi, input logic [2:0] ri,
                         input logic [31:0] a_lo, input logic [31:0] a_hi,
                         input logic [31:0] d, input logic nk);
        mode = m; sgn = s; reduced = red; q_sel = qi; r_sel = ri;
        lo = a_lo; hi = a_hi; dv = d; n_in = nk;
        start = 1'b1;
    endtask

    task automatic issue(input string tag, input logic [1:0] m, input logic s, input logic red,
                         input logic [2:0] qi, input logic [2:0] ri,
                         input logic [31:0] a_lo, input logic [31:0] a_hi,
                         input logic [31:0] d, input logic nk);
        exp_t e;
        @(negedge clk);
        e    = model(m, s, red, qi, ri, a_lo, a_hi, d, nk);
        e.t0 = cyc;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        drive(m, s, red, qi, ri, a_lo, a_hi, d, nk);
        @(negedge clk);
        start = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // Monitor: compare every done pulse against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                stray++;
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check("R10", "latency", 32'(cyc - e.t0), 32'(e.lat));
                check(t, "div0", {31'd0, div0}, {31'd0, e.div0});
                check(t, "wr_q", {31'd0, wr_q}, {31'd0, e.wq});
                check(t, "wr_r", {31'd0, wr_r}, {31'd0, e.wr});
                check(t, "flags_we", {31'd0, flags_we}, {31'd0, e.fwe});
                if (e.fwe) begin
                    check(t, "NZVC", {28'd0, flag_n, flag_z, flag_v, flag_c},
                          {28'd0, e.n, e.z, e.v, 1'b0});
                end
                if (e.wq) check(t, "res_q", res_q, e.q);
                if (e.wr) check(t, "res_r", res_r, e.r);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10", "reset outputs", {26'd0, done, div0, wr_q, wr_r, flags_we, flag_v}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 unsigned word: 100000 / 7
        issue("R2", 2'd0, 1'b0, 1'b0, 3'd1, 3'd2, 32'd100000, 32'd0, 32'd7, 1'b0);
        // R9 signed word, negative dividend and negative divisor
        issue("R9", 2'd0, 1'b1, 1'b0, 3'd1, 3'd2, -32'sd100, 32'd0, 32'd7, 1'b0);
        issue("R9", 2'd0, 1'b1, 1'b0, 3'd1, 3'd2, 32'd100, 32'd0, 32'h0000_FFF9, 1'b0);
        // R3 word overflow, unsigned and signed boundaries
        issue("R3", 2'd0, 1'b0, 1'b0, 3'd1, 3'd2, 32'h0001_0000, 32'd0, 32'd1, 1'b1);
        issue("R4", 2'd0, 1'b0, 1'b0, 3'd1, 3'd2, 32'h0001_0000, 32'd0, 32'd1, 1'b0);
        issue("R3", 2'd0, 1'b1, 1'b0, 3'd1, 3'd2, 32'h0000_8000, 32'd0, 32'd1, 1'b0);
        issue("R3", 2'd0, 1'b1, 1'b0, 3'd1, 3'd2, 32'hFFFF_8000, 32'd0, 32'd1, 1'b0);
        issue("R3", 2'd0, 1'b0, 1'b0, 3'd1, 3'd2, 32'h0000_FFFF, 32'd0, 32'd1, 1'b0);
        // R1 zero divisor, word form looks only at the low half
        issue("R1", 2'd0, 1'b0, 1'b0, 3'd1, 3'd2, 32'd55, 32'd0, 32'h0001_0000, 1'b0);
        issue("R1", 2'd1, 1'b1, 1'b0, 3'd1, 3'd2, 32'd55, 32'd0, 32'd0, 1'b0);
        // R5 long form results, including a zero quotient
        issue("R5", 2'd1, 1'b0, 1'b0, 3'd1, 3'd2, 32'hFFFF_FFFF, 32'd0, 32'd3, 1'b1);
        issue("R5", 2'd1, 1'b1, 1'b0, 3'd1, 3'd2, 32'd5, 32'd0, 32'hFFFF_FFF9, 1'b1);
        // R6 long signed minimum divided by -1 overflows
        issue("R6", 2'd1, 1'b1, 1'b0, 3'd1, 3'd2, 32'h8000_0000, 32'd0, 32'hFFFF_FFFF, 1'b1);
        // R7 equal indices write only the quotient
        issue("R7", 2'd1, 1'b0, 1'b0, 3'd4, 3'd4, 32'd1000, 32'd0, 32'd33, 1'b0);
        issue("R7", 2'd2, 1'b0, 1'b0, 3'd4, 3'd4, 32'd1000, 32'd1, 32'd33, 1'b0);
        // R8 reduced long form, both index cases, and no effect in quad form
        issue("R8", 2'd1, 1'b0, 1'b1, 3'd3, 3'd5, 32'd1000, 32'd0, 32'd33, 1'b0);
        issue("R8", 2'd1, 1'b0, 1'b1, 3'd3, 3'd3, 32'd1000, 32'd0, 32'd33, 1'b0);
        issue("R8", 2'd3, 1'b0, 1'b1, 3'd3, 3'd5, 32'd1000, 32'd0, 32'd33, 1'b0);
        // R6 quad form: success with N set, overflow, signed negative dividend
        issue("R6", 2'd2, 1'b0, 1'b0, 3'd1, 3'd2, 32'd0, 32'd1, 32'd2, 1'b0);
        issue("R6", 2'd2, 1'b0, 1'b0, 3'd1, 3'd2, 32'd0, 32'd2, 32'd2, 1'b0);
        issue("R9", 2'd2, 1'b1, 1'b0, 3'd1, 3'd2, 32'd1, 32'hFFFF_FFFF, 32'd2, 1'b0);

        // R11 a start while busy (zero divisor) must be ignored
        begin
            exp_t e;
            @(negedge clk);
            e    = model(2'd1, 1'b0, 1'b0, 3'd1, 3'd2, 32'd77, 32'd0, 32'd7, 1'b0);
            e.t0 = cyc;
            exp_q.push_back(e);
            tag_q.push_back("R11");
            drive(2'd1, 1'b0, 1'b0, 3'd1, 3'd2, 32'd77, 32'd0, 32'd7, 1'b0);
            @(negedge clk);
            start = 1'b0;
            repeat (5) @(negedge clk);
            drive(2'd1, 1'b0, 1'b0, 3'd1, 3'd2, 32'd9, 32'd0, 32'd0, 1'b0);
            @(negedge clk);
            start = 1'b0;
            while (exp_q.size() != 0) @(negedge clk);
            repeat (80) @(negedge clk);
            check("R11", "stray done count", 32'(stray), 32'd0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule